// File: doc/BRIEF.md
# Registered Code Unscrambler

This block recovers a plain code from a scrambled one. The scrambling it undoes works in two steps: add one to the plain code, with wrap-around at the code width, then rotate the sum right by one bit. The block reverses this in the opposite order. It rotates the incoming scrambled code left by one bit, then subtracts one, again with wrap-around. It is built for 3-bit codes by default, and the code width is a parameter.

The result is captured in flip-flops on the rising clock edge that follows a cycle in which the input strobe is high. The registered code then holds until the next strobed input arrives. A flag reports that at least one result has been captured since reset. The reset is synchronous and active high.

Top module: `code_unscramble_reg`

## Requirements
- R1: While `rst` is high at a rising edge, that edge sets `plain_code` to all zeros and `plain_valid` to 0.
- R2: When `enc_valid` is high at a rising edge and `rst` is low, `plain_code` after that edge equals the scrambled input rotated left by one bit and then decremented by one modulo 2^CODE_W. The rotate-left moves bit i to bit (i+1) mod CODE_W.
- R3: A scrambled input with only the top bit set (3'b100 at the default width) unscrambles to all zeros.
- R4: A scrambled input of all zeros unscrambles to all ones (3'b111 at the default width), because the decrement wraps.
- R5: `plain_valid` goes to 1 on the edge after the first strobed input following reset. It then stays at 1 until the next reset.
- R6: When `enc_valid` is low at a rising edge, `plain_code` keeps its value, whatever is on `enc_code`.
- R7: For every plain code p, scrambling p (add one, then rotate right) and feeding the result to the block returns p.
- R8: Reset takes precedence over a strobed input at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_valid | input | 1 | Strobe: `enc_code` is to be captured at this edge |
| enc_code | input | CODE_W | Scrambled code |
| plain_valid | output | 1 | At least one result captured since reset |
| plain_code | output | CODE_W | Registered unscrambled code |

## Verification
The bench builds two instances. One uses the default CODE_W of 3. The other uses CODE_W of 5, with its own input code and sharing the clock, reset and strobe. The 3-bit instance makes the exhaustive round trip over all eight codes practical, along with the wrap from all zeros to all ones. The 5-bit instance shows that the rotation wiring and the wrap-around decrement scale with the parameter, covering all 32 codes. Hold, sticky-flag and reset-priority scenarios run on both widths at once.

// File: rtl/unscramble_pkg.sv
package unscramble_pkg;
  localparam int DEFAULT_CODE_W = 3;
  localparam int ROT_AMOUNT     = 1;
endpackage

// File: rtl/rotl_stage.sv
module rotl_stage #(
  parameter int W   = unscramble_pkg::DEFAULT_CODE_W,
  parameter int AMT = unscramble_pkg::ROT_AMOUNT
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int SH = AMT % W;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[(i + SH) % W] = din[i];
  end
endmodule

// File: rtl/wrap_dec_stage.sv
module wrap_dec_stage #(
  parameter int W = unscramble_pkg::DEFAULT_CODE_W
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] ONE = W'(1);
  always_comb dout = din - ONE;
endmodule

// File: rtl/hold_reg.sv
module hold_reg #(
  parameter int W = unscramble_pkg::DEFAULT_CODE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         seen
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      seen <= 1'b0;
    end else if (load) begin
      q    <= d;
      seen <= 1'b1;
    end
  end
endmodule

// File: rtl/code_unscramble_reg.sv
module code_unscramble_reg #(
  parameter int CODE_W = unscramble_pkg::DEFAULT_CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_valid,
  input  logic [CODE_W-1:0] enc_code,
  output logic              plain_valid,
  output logic [CODE_W-1:0] plain_code
);
  logic [CODE_W-1:0] rotated;
  logic [CODE_W-1:0] decremented;

  rotl_stage #(.W(CODE_W), .AMT(unscramble_pkg::ROT_AMOUNT)) u_rotl (
    .din  (enc_code),
    .dout (rotated)
  );

  wrap_dec_stage #(.W(CODE_W)) u_dec (
    .din  (rotated),
    .dout (decremented)
  );

  hold_reg #(.W(CODE_W)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .load (enc_valid),
    .d    (decremented),
    .q    (plain_code),
    .seen (plain_valid)
  );
endmodule

// File: rtl/code_unscramble_reg_chk.sv
module code_unscramble_reg_chk #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              enc_valid,
  input logic [CODE_W-1:0] enc_code,
  input logic              plain_valid,
  input logic [CODE_W-1:0] plain_code
);
  localparam logic [CODE_W-1:0] TOP_ONLY = {1'b1, {(CODE_W-1){1'b0}}};

  function automatic logic [CODE_W-1:0] scramble(input logic [CODE_W-1:0] p);
    logic [CODE_W-1:0] s;
    s = p + CODE_W'(1);
    return {s[0], s[CODE_W-1:1]};
  endfunction

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (plain_code == '0 && !plain_valid)); // R1
  AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (rst) enc_valid |=> scramble(plain_code) == $past(enc_code)); // R2
  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (rst) (enc_valid && enc_code == TOP_ONLY) |=> plain_code == '0); // R3
  AST_ZERO_WRAPS: assert property (@(posedge clk) disable iff (rst) (enc_valid && enc_code == '0) |=> plain_code == '1); // R4
  AST_VALID_SETS: assert property (@(posedge clk) disable iff (rst) enc_valid |=> plain_valid); // R5
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst) plain_valid |=> plain_valid); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !enc_valid |=> $stable(plain_code)); // R6
endmodule

bind code_unscramble_reg code_unscramble_reg_chk #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .enc_valid   (enc_valid),
  .enc_code    (enc_code),
  .plain_valid (plain_valid),
  .plain_code  (plain_code)
);

// File: tb/code_unscramble_reg_bench.sv
`timescale 1ns/1ps
module code_unscramble_reg_bench;
  localparam int WN = 3;
  localparam int WW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enc_valid = 1'b0;
  logic [WN-1:0] enc_n = '0;
  logic [WW-1:0] enc_w = '0;
  logic          pv_n, pv_w;
  logic [WN-1:0] pc_n;
  logic [WW-1:0] pc_w;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  code_unscramble_reg #(.CODE_W(WN)) u_code_unscramble_reg (
    .clk(clk), .rst(rst), .enc_valid(enc_valid), .enc_code(enc_n),
    .plain_valid(pv_n), .plain_code(pc_n)
  );

  code_unscramble_reg #(.CODE_W(WW)) u_wide (
    .clk(clk), .rst(rst), .enc_valid(enc_valid), .enc_code(enc_w),
    .plain_valid(pv_w), .plain_code(pc_w)
  );

  function automatic int scramble(input int p, input int w);
    int s;
    s = (p + 1) % (1 << w);
    return (s >> 1) | ((s & 1) << (w - 1));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input int cn, input int cw);
    @(negedge clk);
    enc_valid = v;
    enc_n = WN'(cn);
    enc_w = WW'(cw);
    @(posedge clk);
    @(negedge clk);
    enc_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    chk("R1 code", int'(pc_n), 0);
    chk("R1 valid", int'(pv_n), 0);
    chk("R1 wide code", int'(pc_w), 0);
    chk("R1 wide valid", int'(pv_w), 0);
  endtask

  task automatic t_known_vectors();
    step(1'b1, 4, 16);
    chk("R3 100->000", int'(pc_n), 0);
    chk("R3 wide top bit", int'(pc_w), 0);
    chk("R5 valid set", int'(pv_n), 1);
    step(1'b1, 0, 0);
    chk("R4 000->111", int'(pc_n), 7);
    chk("R4 wide zero wrap", int'(pc_w), 31);
  endtask

  task automatic t_round_trip();
    for (int p = 0; p < 8; p++) begin
      step(1'b1, scramble(p, WN), scramble(p, WW));
      chk("R7 narrow round trip", int'(pc_n), p);
    end
    for (int p = 0; p < 32; p++) begin
      step(1'b1, scramble(p, WN), scramble(p, WW));
      chk("R2 wide round trip", int'(pc_w), p);
    end
  endtask

  task automatic t_hold();
    step(1'b1, scramble(5, WN), scramble(19, WW));
    chk("R2 load", int'(pc_n), 5);
    for (int k = 0; k < 4; k++) begin
      step(1'b0, k * 3 + 1, k * 7 + 2);
      chk("R6 narrow hold", int'(pc_n), 5);
      chk("R6 wide hold", int'(pc_w), 19);
      chk("R5 valid sticky", int'(pv_n), 1);
    end
  endtask

  task automatic t_valid_first();
    t_reset();
    step(1'b0, 3, 3);
    chk("R5 valid low before strobe", int'(pv_n), 0);
    step(1'b1, scramble(2, WN), scramble(2, WW));
    chk("R5 valid after strobe", int'(pv_w), 1);
    chk("R2 after strobe", int'(pc_n), 2);
  endtask

  task automatic t_reset_priority();
    @(negedge clk);
    rst = 1'b1; enc_valid = 1'b1; enc_n = 3'd0; enc_w = 5'd0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0; enc_valid = 1'b0;
    chk("R8 code cleared", int'(pc_n), 0);
    chk("R8 valid cleared", int'(pv_n), 0);
    chk("R8 wide cleared", int'(pc_w), 0);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_known_vectors();
    t_round_trip();
    t_hold();
    t_valid_first();
    t_reset_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule